// File: doc/BRIEF.md
# Bus-Command Channel Readout Controller

This block is the command side of a multi-channel measurement module on a crate dataway. A host issues single-cycle commands made of a function code, a subaddress and a write word. One function code loads a starting channel. Another returns the stored result of the current channel, one word per command. Each stored result is a two-word pair: a most-significant word, and a least-significant word that also carries the ripple value and the range code. The block reads the result store through an external asynchronous read port, one address output and the data inputs.

Every command gets a registered response one cycle later. The response holds an accepted flag (X), a response flag (Q) and a data word. After both words of a channel have been read, the channel address steps to the next channel and wraps at the last one. A word-order input selects which word of the pair comes first. Reads must follow the load, and each other, within a window of clock cycles; a late read is refused with Q low. While the scan engine reports busy, for example during calibration or ripple cycles, the block refuses every command.

Top module: `rdo_readout_ctrl`

## Requirements
- R1: After reset, rsp_valid, rsp_x, rsp_q and rsp_data are all 0, and the timing window counts as expired, so a read issued before any load gets X=1, Q=0.
- R2: A command with function 17 (while not busy) answers X=1, Q=1, loads the channel address from cmd_wdata[CH_W-1:0] (0 if that value is CHANNELS or more), points to the first word of the pair and restarts the timing window.
- R3: An accepted function-0 read returns the current word and then moves to the other word of the pair; after the second word the channel address increments, and from CHANNELS-1 it wraps to 0.
- R4: With fmt_lsw_first=0 the first word of a pair is the most-significant word and the second is the least-significant word; with fmt_lsw_first=1 the order is reversed. The input is sampled on each read.
- R5: The least-significant word is {mem_frac, mem_ripple, mem_range}, with the range code in the low RANGE_W bits and the ripple value in the next RIPPLE_W bits.
- R6: A read is accepted (X=1, Q=1) only if no more than TIMEOUT_CYC clock cycles lie between its strobe and the strobe of the last load or accepted read. A later read gets X=1, Q=0 and data 0, resets the word pointer to the first word, and leaves the address unchanged. Further reads stay refused until a new load.
- R7: A command strobed while scan_busy=1 gets X=0, Q=0 and data 0, and changes neither the channel address nor the word pointer.
- R8: A function code other than 0 or 17 gets X=0, Q=0 and data 0, and changes no state.
- R9: The subaddress has no effect on any function: all of its values give the same response.
- R10: rsp_valid is 1 exactly in the cycle after a strobe. Without a strobe all response outputs are 0, and any response with Q=0 carries data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| cmd_func | input | FN_W | Function code |
| cmd_subaddr | input | SA_W | Subaddress (ignored) |
| cmd_wdata | input | DATA_W | Write word; low CH_W bits are the channel on a load |
| scan_busy | input | 1 | Scan engine busy, all commands refused |
| fmt_lsw_first | input | 1 | 1 returns the least-significant word first |
| mem_addr | output | CH_W | Channel address to the result store |
| mem_msw | input | DATA_W | Most-significant word of the addressed channel |
| mem_frac | input | DATA_W-RIPPLE_W-RANGE_W | Low fraction bits of the addressed channel |
| mem_ripple | input | RIPPLE_W | Ripple value of the addressed channel |
| mem_range | input | RANGE_W | Range code of the addressed channel |
| rsp_valid | output | 1 | Response present |
| rsp_x | output | 1 | Command accepted |
| rsp_q | output | 1 | Response flag |
| rsp_data | output | DATA_W | Read word (0 unless Q=1 on a read) |

## Verification
Directed runs read channels in pairs with both word orders, starting near the top channel so that the wrap to 0 and the order swap are separated from plain increments. The timing window is probed at a gap of exactly the limit and one cycle beyond, to locate the boundary to the cycle. Busy strobes and unknown function codes are placed between the two words of a pair: a disturbed pointer or address would show up in the next accepted word. Seeded random mixes of loads, reads, rejects and idle gaps of varied length, with random subaddresses and order bits, test pointer and window state across long sequences against a bench model.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
    // Classified command after decoding and busy gating
    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_LOAD   = 2'd1,
        CMD_READ   = 2'd2,
        CMD_REJECT = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/rdo_cmd_decode.sv
module rdo_cmd_decode #(
    parameter int FN_W    = 5,
    parameter int FN_LOAD = 17,
    parameter int FN_READ = 0
) (
    input  logic                 stb,
    input  logic                 busy,
    input  logic [FN_W-1:0]      func,
    output rdo_pkg::cmd_kind_e   kind
);
    localparam logic [FN_W-1:0] LOAD_CODE = FN_W'(FN_LOAD);
    localparam logic [FN_W-1:0] READ_CODE = FN_W'(FN_READ);

    always_comb begin
        kind = rdo_pkg::CMD_NONE;
        if (stb) begin
            if (busy)                   kind = rdo_pkg::CMD_REJECT;
            else if (func == LOAD_CODE) kind = rdo_pkg::CMD_LOAD;
            else if (func == READ_CODE) kind = rdo_pkg::CMD_READ;
            else                        kind = rdo_pkg::CMD_REJECT;
        end
    end
endmodule

// File: rtl/rdo_window_timer.sv
module rdo_window_timer #(
    parameter int LIMIT = 3750000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)             cnt_d = '0;
        else if (cnt_q < CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    // Reset value is the saturated count: no window is open after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_MAX;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == CNT_MAX);
endmodule

// File: rtl/rdo_word_order.sv
module rdo_word_order #(
    parameter int DATA_W   = 16,
    parameter int RIPPLE_W = 4,
    parameter int RANGE_W  = 4
) (
    input  logic [DATA_W-1:0]                  msw,
    input  logic [DATA_W-RIPPLE_W-RANGE_W-1:0] frac,
    input  logic [RIPPLE_W-1:0]                ripple,
    input  logic [RANGE_W-1:0]                 range_code,
    input  logic                               lsw_first,
    input  logic                               second,
    output logic [DATA_W-1:0]                  word
);
    logic [DATA_W-1:0] lsw;
    logic              pick_lsw;

    assign lsw      = {frac, ripple, range_code};
    assign pick_lsw = lsw_first ^ second;
    assign word     = pick_lsw ? lsw : msw;
endmodule

// File: rtl/rdo_readout_ctrl.sv
module rdo_readout_ctrl #(
    parameter int CHANNELS    = 32,
    parameter int DATA_W      = 16,
    parameter int FN_W        = 5,
    parameter int SA_W        = 4,
    parameter int RIPPLE_W    = 4,
    parameter int RANGE_W     = 4,
    parameter int FN_LOAD     = 17,
    parameter int FN_READ     = 0,
    parameter int TIMEOUT_CYC = 3750000,
    localparam int CH_W       = $clog2(CHANNELS),
    localparam int FRAC_W     = DATA_W - RIPPLE_W - RANGE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_stb,
    input  logic [FN_W-1:0]     cmd_func,
    input  logic [SA_W-1:0]     cmd_subaddr,
    input  logic [DATA_W-1:0]   cmd_wdata,
    input  logic                scan_busy,
    input  logic                fmt_lsw_first,
    output logic [CH_W-1:0]     mem_addr,
    input  logic [DATA_W-1:0]   mem_msw,
    input  logic [FRAC_W-1:0]   mem_frac,
    input  logic [RIPPLE_W-1:0] mem_ripple,
    input  logic [RANGE_W-1:0]  mem_range,
    output logic                rsp_valid,
    output logic                rsp_x,
    output logic                rsp_q,
    output logic [DATA_W-1:0]   rsp_data
);
    localparam logic [CH_W-1:0] LAST_CH  = CH_W'(CHANNELS - 1);
    localparam logic [CH_W:0]   CHAN_LIM = (CH_W + 1)'(CHANNELS);

    typedef struct packed {
        logic [CH_W-1:0]   addr;
        logic              second;
        logic              valid;
        logic              x;
        logic              q;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t             s_d, s_q;
    rdo_pkg::cmd_kind_e kind;
    logic               expired;
    logic               restart;
    logic [DATA_W-1:0]  cur_word;
    logic [CH_W-1:0]    load_ch;

    rdo_cmd_decode #(
        .FN_W    (FN_W),
        .FN_LOAD (FN_LOAD),
        .FN_READ (FN_READ)
    ) u_dec (
        .stb  (cmd_stb),
        .busy (scan_busy),
        .func (cmd_func),
        .kind (kind)
    );

    rdo_window_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expired (expired)
    );

    rdo_word_order #(
        .DATA_W   (DATA_W),
        .RIPPLE_W (RIPPLE_W),
        .RANGE_W  (RANGE_W)
    ) u_ord (
        .msw        (mem_msw),
        .frac       (mem_frac),
        .ripple     (mem_ripple),
        .range_code (mem_range),
        .lsw_first  (fmt_lsw_first),
        .second     (s_q.second),
        .word       (cur_word)
    );

    // Out-of-range channel numbers fall back to channel 0
    assign load_ch = ({1'b0, cmd_wdata[CH_W-1:0]} < CHAN_LIM) ? cmd_wdata[CH_W-1:0] : '0;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.x     = 1'b0;
        s_d.q     = 1'b0;
        s_d.data  = '0;
        restart   = 1'b0;
        case (kind)
            rdo_pkg::CMD_LOAD: begin
                s_d.valid  = 1'b1;
                s_d.x      = 1'b1;
                s_d.q      = 1'b1;
                s_d.addr   = load_ch;
                s_d.second = 1'b0;
                restart    = 1'b1;
            end
            rdo_pkg::CMD_READ: begin
                s_d.valid = 1'b1;
                s_d.x     = 1'b1;
                if (!expired) begin
                    s_d.q   = 1'b1;
                    s_d.data = cur_word;
                    restart = 1'b1;
                    if (s_q.second) begin
                        s_d.second = 1'b0;
                        s_d.addr   = (s_q.addr == LAST_CH) ? '0 : s_q.addr + 1'b1;
                    end else begin
                        s_d.second = 1'b1;
                    end
                end else begin
                    s_d.second = 1'b0;
                end
            end
            rdo_pkg::CMD_REJECT: begin
                s_d.valid = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_addr  = s_q.addr;
    assign rsp_valid = s_q.valid;
    assign rsp_x     = s_q.x;
    assign rsp_q     = s_q.q;
    assign rsp_data  = s_q.data;
endmodule

// File: rtl/rdo_readout_chk.sv
module rdo_readout_chk #(
    parameter int CHANNELS = 32,
    parameter int DATA_W   = 16,
    parameter int FN_W     = 5,
    parameter int SA_W     = 4,
    parameter int FN_LOAD  = 17,
    parameter int FN_READ  = 0,
    localparam int CH_W    = $clog2(CHANNELS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_stb,
    input logic [FN_W-1:0]   cmd_func,
    input logic [SA_W-1:0]   cmd_subaddr,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic              scan_busy,
    input logic [CH_W-1:0]   mem_addr,
    input logic              rsp_valid,
    input logic              rsp_x,
    input logic              rsp_q,
    input logic [DATA_W-1:0] rsp_data
);
    localparam logic [FN_W-1:0] LOAD_CODE = FN_W'(FN_LOAD);
    localparam logic [FN_W-1:0] READ_CODE = FN_W'(FN_READ);
    localparam logic [CH_W:0]   CHAN_LIM  = (CH_W + 1)'(CHANNELS);

    logic [CH_W-1:0] wr_chan;
    logic            wr_chan_ok;
    logic            is_load, is_read, is_bad;

    assign wr_chan    = cmd_wdata[CH_W-1:0];
    assign wr_chan_ok = ({1'b0, wr_chan} < CHAN_LIM);
    assign is_load    = cmd_stb && !scan_busy && (cmd_func == LOAD_CODE);
    assign is_read    = cmd_stb && !scan_busy && (cmd_func == READ_CODE);
    assign is_bad     = cmd_stb && !scan_busy && !is_load && !is_read;

    // R10: a response follows every strobe, and only a strobe
    a_r10_rsp_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> rsp_valid);
    a_r10_quiet_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |=> (!rsp_valid && !rsp_x && !rsp_q && rsp_data == '0));
    a_r10_noq_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_q) |-> (rsp_data == '0));
    // R7: busy refuses and holds the address
    a_r7_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && scan_busy) |=> (!rsp_x && !rsp_q && $stable(mem_addr)));
    // R8: unknown codes refused and hold the address
    a_r8_bad_fn: assert property (@(posedge clk) disable iff (!rst_n)
        is_bad |=> (!rsp_x && !rsp_q && $stable(mem_addr)));
    // R2: load acknowledged and address taken
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> (rsp_x && rsp_q &&
                     mem_addr == ($past(wr_chan_ok) ? $past(wr_chan) : '0)));
    // R6: reads always accepted, Q may drop
    a_r6_read_x: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |=> rsp_x);
    // R3: address stays within the channel count
    a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, mem_addr} < CHAN_LIM));
    // R9: command fields are driven when strobed
    a_r9_fields_known: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> !$isunknown({cmd_func, cmd_subaddr, cmd_wdata, scan_busy}));
endmodule

bind rdo_readout_ctrl rdo_readout_chk #(
    .CHANNELS (CHANNELS),
    .DATA_W   (DATA_W),
    .FN_W     (FN_W),
    .SA_W     (SA_W),
    .FN_LOAD  (FN_LOAD),
    .FN_READ  (FN_READ)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_stb     (cmd_stb),
    .cmd_func    (cmd_func),
    .cmd_subaddr (cmd_subaddr),
    .cmd_wdata   (cmd_wdata),
    .scan_busy   (scan_busy),
    .mem_addr    (mem_addr),
    .rsp_valid   (rsp_valid),
    .rsp_x       (rsp_x),
    .rsp_q       (rsp_q),
    .rsp_data    (rsp_data)
);

// File: tb/rdo_readout_ctrl_test.sv
module rdo_readout_ctrl_test;
    localparam int T = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_stb = 1'b0;
    logic [4:0]  cmd_func = '0;
    logic [3:0]  cmd_subaddr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        scan_busy = 1'b0;
    logic        fmt_lsw_first = 1'b0;
    logic [4:0]  mem_addr;
    logic [15:0] mem_msw;
    logic [7:0]  mem_frac;
    logic [3:0]  mem_ripple, mem_range;
    logic        rsp_valid, rsp_x, rsp_q;
    logic [15:0] rsp_data;

    int tests = 0, fails = 0;
    int ncyc = 0;
    bit done = 0;

    // bench model
    logic [4:0] m_addr = '0;
    bit         m_sec = 0;
    bit         m_live = 0;
    int         m_last = 0;

    always #10 clk = ~clk;

    rdo_readout_ctrl #(.TIMEOUT_CYC(T)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_func(cmd_func),
        .cmd_subaddr(cmd_subaddr), .cmd_wdata(cmd_wdata), .scan_busy(scan_busy),
        .fmt_lsw_first(fmt_lsw_first), .mem_addr(mem_addr), .mem_msw(mem_msw),
        .mem_frac(mem_frac), .mem_ripple(mem_ripple), .mem_range(mem_range),
        .rsp_valid(rsp_valid), .rsp_x(rsp_x), .rsp_q(rsp_q), .rsp_data(rsp_data));

    function automatic logic [15:0] f_msw(input logic [4:0] ch);
        return 16'h8000 | 16'(ch * 16'h0123);
    endfunction
    function automatic logic [7:0] f_frac(input logic [4:0] ch);
        return 8'(ch * 7 + 3);
    endfunction
    function automatic logic [3:0] f_rip(input logic [4:0] ch);
        return 4'(ch + 5);
    endfunction
    function automatic logic [3:0] f_rng(input logic [4:0] ch);
        return 4'(ch * 3);
    endfunction
    // R4 order, R5 layout of the low word
    function automatic logic [15:0] f_word(input logic [4:0] ch, input bit sec, input bit fm);
        logic [15:0] lsw;
        lsw = {f_frac(ch), f_rip(ch), f_rng(ch)};
        return (fm ^ sec) ? lsw : f_msw(ch);
    endfunction

    // result store model
    always_comb begin
        mem_msw    = f_msw(mem_addr);
        mem_frac   = f_frac(mem_addr);
        mem_ripple = f_rip(mem_addr);
        mem_range  = f_rng(mem_addr);
    end

    task automatic tick();
        @(negedge clk);
        ncyc++;
    endtask

    task automatic check(input string tag, input logic [18:0] got, input logic [18:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got valid/x/q/data=%0b/%0b/%0b/%h expected %0b/%0b/%0b/%h",
                     tag, got[18], got[17], got[16], got[15:0],
                     exp[18], exp[17], exp[16], exp[15:0]);
        end
    endtask

    task automatic do_cmd(input logic [4:0] fn, input logic [3:0] sa,
                          input logic [15:0] wd, input bit bz, input bit fm);
        string       tag;
        bit          ex, eq;
        logic [15:0] ed;
        int          e;
        tick();
        cmd_stb = 1'b1; cmd_func = fn; cmd_subaddr = sa; cmd_wdata = wd;
        scan_busy = bz; fmt_lsw_first = fm;
        e = ncyc;
        ex = 0; eq = 0; ed = '0;
        if (bz) begin
            tag = "R7 busy";
        end else if (fn == 5'd17) begin
            tag = "R2 load";
            ex = 1; eq = 1;
            m_addr = wd[4:0]; m_sec = 0; m_live = 1; m_last = e;
        end else if (fn == 5'd0) begin
            ex = 1;
            if (m_live && (e - m_last) <= T) begin
                tag = "R3 R4 R5 read";
                eq = 1;
                ed = f_word(m_addr, m_sec, fm);
                if (m_sec) m_addr = 5'(m_addr + 1);
                m_sec = !m_sec;
                m_last = e;
            end else begin
                tag = "R6 late read";
                m_sec = 0; m_live = 0;
            end
        end else begin
            tag = "R8 bad function";
        end
        if (sa != 0) tag = {tag, " R9 subaddr"};
        tick();
        cmd_stb = 1'b0; scan_busy = 1'b0;
        check(tag, {rsp_valid, rsp_x, rsp_q, rsp_data}, {1'b1, ex, eq, ed});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            if (i == 0) check("R10 idle", {rsp_valid, rsp_x, rsp_q, rsp_data}, 19'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R1 reset", {rsp_valid, rsp_x, rsp_q, rsp_data}, 19'd0);
        // R1: read before any load is refused
        do_cmd(5'd0, 4'd0, 16'h0, 0, 0);
        // R3 wrap from 31 to 0, default order
        do_cmd(5'd17, 4'd7, 16'hFFDE, 0, 0);
        for (int i = 0; i < 6; i++) do_cmd(5'd0, 4'(i * 3), 16'h0, 0, 0);
        // R4 swapped order
        do_cmd(5'd17, 4'd15, 16'h0005, 0, 1);
        do_cmd(5'd0, 4'd0, 16'h0, 0, 1);
        // R7 and R8 between the words of a pair
        do_cmd(5'd0, 4'd2, 16'h0, 1, 1);
        do_cmd(5'd5, 4'd0, 16'h0, 0, 1);
        do_cmd(5'd17, 4'd0, 16'h0003, 1, 1);
        do_cmd(5'd0, 4'd9, 16'h0, 0, 1);
        // R6 window boundary
        do_cmd(5'd17, 4'd0, 16'h000A, 0, 0);
        idle(T - 2);
        do_cmd(5'd0, 4'd0, 16'h0, 0, 0);
        idle(T - 1);
        do_cmd(5'd0, 4'd0, 16'h0, 0, 0);
        do_cmd(5'd0, 4'd0, 16'h0, 0, 0);
        do_cmd(5'd17, 4'd1, 16'h000A, 0, 0);
        do_cmd(5'd0, 4'd0, 16'h0, 0, 0);
        // seeded random mix
        for (int k = 0; k < 600; k++) begin
            int r;
            logic [4:0] fn;
            r = int'($urandom % 100);
            if (r < 55)      fn = 5'd0;
            else if (r < 75) fn = 5'd17;
            else begin
                fn = 5'($urandom);
                if (fn == 5'd0 || fn == 5'd17) fn = 5'd9;
            end
            do_cmd(fn, 4'($urandom), 16'($urandom), ($urandom % 100) < 12,
                   ($urandom % 4) == 0);
            r = int'($urandom % 100);
            if (r < 10)      idle(int'($urandom % 48));
            else if (r < 25) idle(1 + int'($urandom % 5));
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule